// File: doc/BRIEF.md
# Time-Slot Shared Memory Hub

This hub gives eight processor ports shared access to one byte-addressed memory. Ports are not arbitrated on demand. A four-bit counter runs freely at the processor clock, and each port owns a fixed two-clock window once every sixteen clocks. The window rotates whether or not any port is requesting. A port that raises a request waits for its own window and then gets exactly one access. Because of this, the latency of every access depends only on when the request arrives relative to the rotation.

The address space has two halves. The lower half is writable RAM. The upper half is read-only, and its contents are computed rather than stored. Each access can be a byte, a 16-bit word or a 32-bit long. Data is packed little-endian within a long, and narrow reads come back zero-extended. The address width is a parameter. The default is 12 bits, which gives 2 KB in each half. An address width of 16 gives 32 KB per half.

Top module: `slot_hub`

## Requirements
- R1: After reset the slot counter is 0 and advances by one on every clock. In a cycle with phase k = cycles-since-reset mod 16, port k/2 owns the window. A request that is raised in phase c and held gets its done pulse exactly ((2p+1-c) mod 16)+1 cycles later, where p is the port number.
- R2: A port receives a done pulse only when it has been requesting, and only in the cycle after its own window. With no request there is never a done pulse.
- R3: Done stays high for exactly one clock. At most one port sees done in any cycle.
- R4: The read result is valid on rdata_o of that port in the cycle of its done pulse. It holds until that port's next read completes, and write completions leave it unchanged.
- R5: The size code is 2'b00 for a byte, 2'b01 for a word, and 2'b10 or 2'b11 for a long. Addresses are byte addresses.
- R6: Word accesses ignore address bit 0. Long accesses ignore address bits 1:0.
- R7: Byte n of a long (n = address bits 1:0) occupies data bits 8n+7:8n, which is little-endian order.
- R8: Byte and word reads are returned zero-extended to 32 bits.
- R9: The address MSB selects the region: 0 selects RAM and 1 selects ROM.
- R10: The ROM long at long index k within the ROM half reads as (k * 32'h9E3779B1) mod 2^32.
- R11: A write to the ROM half changes nothing but still completes with a done pulse.
- R12: While reset is held and right after it, every done_o bit and every rdata_o value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NPORTS | Per-port access request, held until done |
| we_i | input | NPORTS | Per-port write (1) or read (0) |
| size_i | input | NPORTS x 2 | Per-port access size code |
| addr_i | input | NPORTS x ADDR_W | Per-port byte address |
| wdata_i | input | NPORTS x 32 | Per-port write data, right-aligned |
| done_o | output | NPORTS | One-clock completion pulse per port |
| rdata_o | output | NPORTS x 32 | Per-port read result, zero-extended |

## Verification
A request raised in phase c completes after ((2p+1-c) mod 16)+1 cycles. The bench keeps its own cycle counter from reset release, so it can compute that number for every access and compare it with the cycle in which done is actually seen. Read data is due in the same cycle as done. The bench compares it against a byte model of the RAM and a computed ROM, and that model is updated in the order in which done pulses are observed. All sampling happens on the falling edge. Done is also confirmed low one cycle later.

// File: rtl/slot_hub_pkg.sv
package slot_hub_pkg;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;

  // byte-lane enables for a write
  function automatic logic [3:0] lane_mask(logic [1:0] sz, logic [1:0] off);
    if (sz == SZ_BYTE)      return 4'b0001 << off;
    else if (sz == SZ_WORD) return off[1] ? 4'b1100 : 4'b0011;
    else                    return 4'b1111;
  endfunction

  // replicate narrow data across lanes
  function automatic logic [31:0] lane_wdata(logic [1:0] sz, logic [31:0] d);
    if (sz == SZ_BYTE)      return {4{d[7:0]}};
    else if (sz == SZ_WORD) return {2{d[15:0]}};
    else                    return d;
  endfunction

  // pick and zero-extend the addressed bytes
  function automatic logic [31:0] lane_extract(logic [1:0] sz, logic [1:0] off,
                                               logic [31:0] l);
    logic [31:0] s;
    if (sz == SZ_BYTE) begin
      s = l >> {off, 3'b000};
      return {24'd0, s[7:0]};
    end else if (sz == SZ_WORD) begin
      s = off[1] ? (l >> 16) : l;
      return {16'd0, s[15:0]};
    end else begin
      return l;
    end
  endfunction

  function automatic logic [31:0] rom_long(logic [31:0] k);
    return k * 32'h9E37_79B1;
  endfunction

endpackage

// File: rtl/slot_hub_rotor.sv
module slot_hub_rotor #(
  parameter int NPORTS = 8,
  localparam int OWN_W = $clog2(NPORTS),
  localparam int CNT_W = OWN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OWN_W-1:0] owner_o,
  output logic             slot_last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign owner_o     = cnt_q[CNT_W-1:1];
  assign slot_last_o = cnt_q[0];

  // R1
  window_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_last_o |=> (slot_last_o && owner_o == $past(owner_o)));

endmodule

// File: rtl/slot_hub_mem.sv
module slot_hub_mem #(
  parameter int ADDR_W = 12,
  localparam int LA_W      = ADDR_W - 2,
  localparam int IDX_W     = ADDR_W - 3,
  localparam int RAM_LONGS = 1 << IDX_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ram_we_i,
  input  logic [3:0]      be_i,
  input  logic [LA_W-1:0] long_addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o
);
  import slot_hub_pkg::*;

  logic [IDX_W-1:0] idx;
  logic             rom_sel;
  logic [31:0]      ram_rd;

  assign idx     = long_addr_i[IDX_W-1:0];
  assign rom_sel = long_addr_i[LA_W-1];

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] ram_q [RAM_LONGS];
    always_ff @(posedge clk_i) begin
      if (ram_we_i && be_i[l]) ram_q[idx] <= wdata_i[8*l +: 8];
    end
    assign ram_rd[8*l +: 8] = ram_q[idx];
  end

  assign rdata_o = rom_sel ? rom_long({{(32-IDX_W){1'b0}}, idx}) : ram_rd;

  // R11
  rom_wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_i |-> !rom_sel);

endmodule

// File: rtl/slot_hub.sv
module slot_hub #(
  parameter int NPORTS = 8,
  parameter int ADDR_W = 12,
  localparam int OWN_W = $clog2(NPORTS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NPORTS-1:0]             req_i,
  input  logic [NPORTS-1:0]             we_i,
  input  logic [NPORTS-1:0][1:0]        size_i,
  input  logic [NPORTS-1:0][ADDR_W-1:0] addr_i,
  input  logic [NPORTS-1:0][31:0]       wdata_i,
  output logic [NPORTS-1:0]             done_o,
  output logic [NPORTS-1:0][31:0]       rdata_o
);
  import slot_hub_pkg::*;

  logic [OWN_W-1:0]  owner;
  logic              slot_last;
  logic              sel_req, sel_we, fire, rom_hit, ram_we;
  logic [1:0]        sel_size;
  logic [ADDR_W-1:0] sel_addr;
  logic [31:0]       sel_wdata, lane_wd, rd_long, rd_val;
  logic [3:0]        be;

  logic [NPORTS-1:0]       done_q;
  logic [NPORTS-1:0][31:0] rdata_q;

  slot_hub_rotor #(.NPORTS(NPORTS)) u_rotor (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .owner_o     (owner),
    .slot_last_o (slot_last)
  );

  assign sel_req   = req_i[owner];
  assign sel_we    = we_i[owner];
  assign sel_size  = size_i[owner];
  assign sel_addr  = addr_i[owner];
  assign sel_wdata = wdata_i[owner];

  // access happens in the window's second clock
  assign fire    = slot_last & sel_req;
  assign rom_hit = sel_addr[ADDR_W-1];
  assign ram_we  = fire & sel_we & ~rom_hit;
  assign be      = lane_mask(sel_size, sel_addr[1:0]);
  assign lane_wd = lane_wdata(sel_size, sel_wdata);

  slot_hub_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ram_we_i    (ram_we),
    .be_i        (be),
    .long_addr_i (sel_addr[ADDR_W-1:2]),
    .wdata_i     (lane_wd),
    .rdata_o     (rd_long)
  );

  assign rd_val = lane_extract(sel_size, sel_addr[1:0], rd_long);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= '0;
      if (fire) begin
        done_q[owner] <= 1'b1;
        if (!sel_we) rdata_q[owner] <= rd_val;
      end
    end
  end

  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  // R3
  done_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));

  for (genvar g = 0; g < NPORTS; g++) begin : g_chk
    // R3
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[g] |=> !done_o[g]);
    // R2
    done_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[g] |-> ($past(req_i[g]) && $past(owner) == OWN_W'(g) && $past(slot_last)));
    // R4
    rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o[g] |-> $stable(rdata_o[g]));
  end

endmodule

// File: tb/slot_hub_bench.sv
`timescale 1ns/1ps
module slot_hub_bench;
  localparam int NP   = 8;
  localparam int AW   = 12;
  localparam int HALF = 1 << (AW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]         req = '0;
  logic [NP-1:0]         we = '0;
  logic [NP-1:0][1:0]    size = '0;
  logic [NP-1:0][AW-1:0] addr = '0;
  logic [NP-1:0][31:0]   wdata = '0;
  logic [NP-1:0]         done_o;
  logic [NP-1:0][31:0]   rdata_o;

  int compared = 0, mismatched = 0, cyc = 0;
  bit finished = 0;
  logic [7:0]  mdl [HALF];
  logic [31:0] last_rd [NP];

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  slot_hub #(.NPORTS(NP), .ADDR_W(AW)) u_slot_hub (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .done_o(done_o), .rdata_o(rdata_o));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_read(logic [1:0] sz, logic [AW-1:0] a);
    logic [31:0] l;
    int b;
    if (a[AW-1]) begin
      l = 32'((a & (HALF - 1)) >> 2) * 32'h9E37_79B1;
    end else begin
      b = int'(a) & ~3;
      l = {mdl[b+3], mdl[b+2], mdl[b+1], mdl[b]};
    end
    case (sz)
      2'b00:   return (l >> (8 * a[1:0])) & 32'hFF;
      2'b01:   return a[1] ? {16'd0, l[31:16]} : {16'd0, l[15:0]};
      default: return l;
    endcase
  endfunction

  function automatic void ref_write(logic [1:0] sz, logic [AW-1:0] a, logic [31:0] d);
    int b;
    if (a[AW-1]) return;
    b = int'(a);
    case (sz)
      2'b00: mdl[b] = d[7:0];
      2'b01: begin b = b & ~1; mdl[b] = d[7:0]; mdl[b+1] = d[15:8]; end
      default: begin
        b = b & ~3;
        mdl[b] = d[7:0]; mdl[b+1] = d[15:8]; mdl[b+2] = d[23:16]; mdl[b+3] = d[31:24];
      end
    endcase
  endfunction

  task automatic access(input int p, input bit w, input logic [1:0] sz,
                        input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    int c, n, e;
    logic [31:0] exp;
    @(negedge clk);
    req[p] = 1'b1; we[p] = w; size[p] = sz; addr[p] = a; wdata[p] = d;
    c = cyc;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done_o[p] && n < 40);
    e = ((2 * p + 1 - (c % 16) + 16) % 16) + 1;
    // R1 latency set by phase; R2 no early grant
    chk(n == e, "R1", 32'(n), 32'(e));
    if (w) begin
      ref_write(sz, a, d);
      chk(rdata_o[p] == last_rd[p], "R4", rdata_o[p], last_rd[p]);
    end else begin
      exp = ref_read(sz, a);
      chk(rdata_o[p] === exp, tag, rdata_o[p], exp);
      last_rd[p] = exp;
    end
    req[p] = 1'b0;
    @(negedge clk);
    chk(done_o[p] == 1'b0, "R3", 32'(done_o[p]), 32'd0);
  endtask

  task automatic init_port(input int p);
    for (int i = p; i < HALF / 4; i += NP)
      access(p, 1'b1, 2'b10, AW'(4 * i), $urandom, "R5");
  endtask

  task automatic rand_port(input int p);
    logic [1:0]    sz;
    logic [AW-1:0] a;
    for (int i = 0; i < 30; i++) begin
      repeat ($urandom % 6) @(negedge clk);
      sz = 2'($urandom % 4);
      a  = AW'($urandom);
      access(p, 1'($urandom), sz, a, $urandom, a[AW-1] ? "R10" : "R5");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    for (int i = 0; i < NP; i++) last_rd[i] = 32'd0;
    repeat (3) @(negedge clk);
    chk(done_o == '0, "R12", 32'(done_o), 32'd0);
    chk(rdata_o == '0, "R12", rdata_o[0], 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o == '0 && rdata_o == '0, "R12", 32'(done_o), 32'd0);

    // R2: idle hub, no done pulses
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(done_o == '0, "R2", 32'(done_o), 32'd0);
    end

    fork
      init_port(0); init_port(1); init_port(2); init_port(3);
      init_port(4); init_port(5); init_port(6); init_port(7);
    join

    // R7 little-endian, R6 alignment, R8 zero extension
    access(0, 1'b1, 2'b10, 12'h020, 32'h1122_3344, "R7");
    access(0, 1'b0, 2'b00, 12'h020, 0, "R7");
    access(1, 1'b0, 2'b00, 12'h023, 0, "R8");
    access(2, 1'b0, 2'b01, 12'h022, 0, "R8");
    access(3, 1'b0, 2'b01, 12'h023, 0, "R6");
    access(4, 1'b0, 2'b10, 12'h022, 0, "R6");
    access(5, 1'b1, 2'b01, 12'h031, 32'hAAAA_5A5A, "R6");
    access(5, 1'b0, 2'b10, 12'h030, 0, "R6");
    access(6, 1'b1, 2'b00, 12'h042, 32'hFFFF_FF9C, "R5");
    access(6, 1'b0, 2'b11, 12'h040, 0, "R5");
    // R9 / R10 ROM reads
    access(7, 1'b0, 2'b10, 12'h800, 0, "R10");
    access(7, 1'b0, 2'b10, 12'hFFF, 0, "R10");
    access(2, 1'b0, 2'b00, 12'h805, 0, "R9");
    access(3, 1'b0, 2'b01, 12'h7FE, 0, "R9");
    // R11 ROM write dropped but completes
    access(4, 1'b1, 2'b10, 12'h810, 32'hDEAD_BEEF, "R11");
    access(4, 1'b0, 2'b10, 12'h810, 0, "R11");
    access(1, 1'b1, 2'b00, 12'h811, 32'h0000_0055, "R11");
    access(1, 1'b0, 2'b00, 12'h811, 0, "R11");

    fork
      rand_port(0); rand_port(1); rand_port(2); rand_port(3);
      rand_port(4); rand_port(5); rand_port(6); rand_port(7);
    join

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule